// File: doc/BRIEF.md
# Cascaded Display RAM Write Addresser

This block turns a stream of display bytes into masked writes to a small display RAM in a segment LCD driver. The RAM is organised as 40 words of 4 row bits. A byte is spread over several successive words, one word per clock cycle. How many bits go into each word depends on the selected multiplex mode: 1, 2, 3 or 4 row bits per word, with the bits taken most significant first and placed into rows in ascending order.

A data pointer selects the word being written. A subaddress counter identifies which device in a cascade currently owns the byte stream. Words are stored only while the counter equals the device's strapped hardware subaddress. The pointer advances whether or not the word is stored.

When the pointer steps past the last word, it wraps to word 0 and the subaddress counter increments. This lets one long byte stream fill several cascaded devices in turn, even when the hand-over falls inside a byte. A command decoder drives the pointer-load, device-select and byte strobes. A read port exposes the stored words.

Top module: `dwa_addresser`

## Requirements
- R1: After reset `busy` is low, the data pointer is 0 and the subaddress counter is 0, so the first byte accepted with `hw_sub` = 0 is stored starting at word 0.
- R2: Mode 0 (static): byte bit 7 goes to row 0 of word p, bit 6 to row 0 of word p+1, and so on down to bit 0 in word p+7. Rows 1 to 3 of these words are unchanged, and the pointer advances by 8.
- R3: Mode 1 (two rows): word p takes bit 7 in row 0 and bit 6 in row 1, word p+1 takes bits 5 and 4, and so on over four words. Rows 2 and 3 are unchanged, and the pointer advances by 4.
- R4: Mode 2 (three rows): words p and p+1 take bits 7,6,5 and 4,3,2 in rows 0,1,2. Word p+2 takes bit 1 in row 0 and bit 0 in row 1, and its row 2 is unchanged. Row 3 is never written, and the pointer advances by 3.
- R5: Mode 3 (four rows): word p takes bits 7,6,5,4 in rows 0 to 3, word p+1 takes bits 3 to 0, and the pointer advances by 2.
- R6: While the subaddress counter differs from `hw_sub`, no RAM bit changes, but the pointer advances exactly as if the word were stored.
- R7: After the pointer passes word 39, the next word is word 0 and the subaddress counter increments modulo 8. The new counter value governs storage for the remaining words of the same byte.
- R8: When idle, a `ptr_load` strobe sets the pointer to `ptr_val`, and a `dev_sel` strobe sets the subaddress counter to `dev_val`. Both take effect for the next byte.
- R9: `busy` is high for exactly as many cycles as the byte has words (8, 4, 3 or 2), starting in the cycle after the byte is accepted. Any `byte_valid`, `ptr_load` or `dev_sel` strobe while `busy` is high is ignored.
- R10: `abort` while `busy` is high stops the byte: no word is written in that cycle or later, and `busy` is low in the next cycle.
- R11: `rd_data` shows the 4-bit word at `rd_addr` one clock cycle after the address is applied. Bit n of the word is row n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Multiplex mode, sampled when a byte is accepted |
| ptr_load | input | 1 | Load-pointer strobe |
| ptr_val | input | 6 | Pointer value to load |
| dev_sel | input | 1 | Device-select strobe |
| dev_val | input | 3 | Subaddress counter value to load |
| hw_sub | input | 3 | Strapped hardware subaddress of this device |
| byte_valid | input | 1 | Display byte strobe |
| byte_data | input | 8 | Display byte |
| abort | input | 1 | Cancels the byte in progress |
| busy | output | 1 | A byte is being distributed over words |
| rd_addr | input | 6 | Read port word address |
| rd_data | output | 4 | Read port word, registered |

## Verification
The hardest case is the subaddress hand-over that falls inside a byte. The pointer must sit within a few words of the end, and the counter must be one below the strapped subaddress. Then the first words of the byte are suppressed and the rest land at the bottom of the RAM. The stimulus loads the pointer to 38, selects a device one below `hw_sub` and sends a static-mode byte. It then checks that only the trailing bits appear, in words 0 to 5, and that a following byte continues at word 6. Randomly placed bytes in all modes then revisit the wrap with other group sizes.

// File: rtl/dwa_pkg.sv
package dwa_pkg;
  localparam int DISP_WORDS = 40;
  localparam int ROW_BITS   = 4;
  localparam int PTR_W      = 6;
  localparam int SUB_W      = 3;
  localparam int BYTE_W     = 8;
  localparam int MODE_W     = 2;

  typedef enum logic [MODE_W-1:0] {
    MUX_STATIC  = 2'd0,
    MUX_HALF    = 2'd1,
    MUX_THIRD   = 2'd2,
    MUX_QUARTER = 2'd3
  } mux_mode_e;
endpackage

// File: rtl/dwa_pointer.sv
module dwa_pointer #(
  parameter int DEPTH  = dwa_pkg::DISP_WORDS,
  parameter int ADDR_W = dwa_pkg::PTR_W,
  parameter int SUB_W  = dwa_pkg::SUB_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              sel_en,
  input  logic [SUB_W-1:0]  sel_val,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr,
  output logic [SUB_W-1:0]  sub
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic at_end;
  assign at_end = (ptr >= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      sub <= '0;
    end else begin
      if (load_en)   ptr <= load_val;
      else if (step) ptr <= at_end ? '0 : ptr + 1'b1;
      if (sel_en)              sub <= sel_val;
      else if (step && at_end) sub <= sub + 1'b1;
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load_en && at_end) |=> (ptr == '0)); // R7
  AST_SUB_BUMP: assert property (@(posedge clk) disable iff (rst)
    (step && !sel_en && at_end) |=> (sub == SUB_W'($past(sub) + 1'b1))); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!step && !load_en) |=> $stable(ptr)); // R8
endmodule

// File: rtl/dwa_packer.sv
module dwa_packer #(
  parameter int DATA_W = dwa_pkg::BYTE_W,
  parameter int ROWS   = dwa_pkg::ROW_BITS,
  parameter int MODE_W = dwa_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] data,
  input  logic              abort,
  output logic              busy,
  output logic              step,
  output logic [ROWS-1:0]   wbits,
  output logic [ROWS-1:0]   wmask
);
  localparam int BL_W = $clog2(DATA_W + 1);

  logic              busy_q;
  logic [DATA_W-1:0] shreg_q;
  logic [BL_W-1:0]   left_q;
  logic [BL_W-1:0]   rows_q;
  logic [BL_W-1:0]   take;

  assign take = (rows_q < left_q) ? rows_q : left_q;
  assign step = busy_q && !abort;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b0;
      shreg_q <= '0;
      left_q  <= '0;
      rows_q  <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        shreg_q <= data;
        left_q  <= BL_W'(DATA_W);
        rows_q  <= BL_W'(mode) + 1'b1;
      end
    end else if (abort) begin
      busy_q <= 1'b0;
    end else begin
      shreg_q <= shreg_q << take;
      left_q  <= left_q - take;
      if (left_q == take) busy_q <= 1'b0;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign wbits[r] = shreg_q[DATA_W-1-r];
    assign wmask[r] = step && (BL_W'(r) < take);
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_q) |=> busy_q); // R9
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    (busy_q && abort) |=> !busy_q); // R10
  AST_MASK_ROWS: assert property (@(posedge clk) disable iff (rst)
    step |-> (wmask[0] && ($countones(wmask) <= int'(rows_q)))); // R4
endmodule

// File: rtl/dwa_ram.sv
module dwa_ram #(
  parameter int DEPTH  = dwa_pkg::DISP_WORDS,
  parameter int ROWS   = dwa_pkg::ROW_BITS,
  parameter int ADDR_W = dwa_pkg::PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [ROWS-1:0]   wbits,
  input  logic [ROWS-1:0]   wmask,
  input  logic [ADDR_W-1:0] raddr,
  output logic [ROWS-1:0]   rdata
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  for (genvar r = 0; r < ROWS; r++) begin : g_slice
    logic mem_q [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wmask[r] && (waddr <= LAST)) mem_q[waddr] <= wbits[r];
    end

    always_ff @(posedge clk) begin
      if (rst)                 rdata[r] <= 1'b0;
      else if (raddr <= LAST)  rdata[r] <= mem_q[raddr];
      else                     rdata[r] <= 1'b0;
    end
  end
endmodule

// File: rtl/dwa_addresser.sv
module dwa_addresser #(
  parameter int DEPTH  = dwa_pkg::DISP_WORDS,
  parameter int ROWS   = dwa_pkg::ROW_BITS,
  parameter int ADDR_W = dwa_pkg::PTR_W,
  parameter int SUB_W  = dwa_pkg::SUB_W,
  parameter int DATA_W = dwa_pkg::BYTE_W,
  parameter int MODE_W = dwa_pkg::MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode,
  input  logic              ptr_load,
  input  logic [ADDR_W-1:0] ptr_val,
  input  logic              dev_sel,
  input  logic [SUB_W-1:0]  dev_val,
  input  logic [SUB_W-1:0]  hw_sub,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              abort,
  output logic              busy,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [ROWS-1:0]   rd_data
);
  logic              step;
  logic              ram_we;
  logic [ROWS-1:0]   wbits;
  logic [ROWS-1:0]   wmask;
  logic [ADDR_W-1:0] ptr;
  logic [SUB_W-1:0]  sub;

  dwa_packer #(.DATA_W(DATA_W), .ROWS(ROWS), .MODE_W(MODE_W)) packer_i (
    .clk(clk), .rst(rst), .start(byte_valid && !busy), .mode(mode),
    .data(byte_data), .abort(abort), .busy(busy), .step(step),
    .wbits(wbits), .wmask(wmask)
  );

  dwa_pointer #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SUB_W(SUB_W)) pointer_i (
    .clk(clk), .rst(rst),
    .load_en(ptr_load && !busy), .load_val(ptr_val),
    .sel_en(dev_sel && !busy), .sel_val(dev_val),
    .step(step), .ptr(ptr), .sub(sub)
  );

  assign ram_we = step && (sub == hw_sub);

  dwa_ram #(.DEPTH(DEPTH), .ROWS(ROWS), .ADDR_W(ADDR_W)) ram_i (
    .clk(clk), .rst(rst), .we(ram_we), .waddr(ptr), .wbits(wbits),
    .wmask(wmask), .raddr(rd_addr), .rdata(rd_data)
  );

  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy); // R9
endmodule

// File: tb/dwa_addresser_tb_top.sv
module dwa_addresser_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic       ptr_load = 1'b0;
  logic [5:0] ptr_val = '0;
  logic       dev_sel = 1'b0;
  logic [2:0] dev_val = '0;
  logic [2:0] hw_sub = '0;
  logic       byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic       abort = 1'b0;
  logic       busy;
  logic [5:0] rd_addr = '0;
  logic [3:0] rd_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  dwa_addresser dut_i (
    .clk(clk), .rst(rst), .mode(mode), .ptr_load(ptr_load), .ptr_val(ptr_val),
    .dev_sel(dev_sel), .dev_val(dev_val), .hw_sub(hw_sub),
    .byte_valid(byte_valid), .byte_data(byte_data), .abort(abort),
    .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [3:0] mram [NW];
  int         mptr = 0;
  logic [2:0] msub = '0;

  int         addr_q [$];
  logic [3:0] exp_q  [$];
  string      tag_q  [$];
  logic       arm = 1'b0;
  logic       arm_d = 1'b0;

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: read data appears one cycle after the address
  always @(posedge clk) arm_d <= arm;
  always @(negedge clk) begin
    if (arm_d && exp_q.size() > 0) begin
      int a;
      logic [3:0] e;
      string t;
      a = addr_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_checks++;
      if (rd_data !== e) begin
        n_fail++;
        $display("FAIL %s word %0d actual=%h expected=%h", t, a, rd_data, e);
      end
    end
  end

  task automatic check_all(input string tag);
    for (int a = 0; a < NW; a++) begin
      @(negedge clk);
      rd_addr = 6'(a);
      arm = 1'b1;
      addr_q.push_back(a);
      exp_q.push_back(mram[a]);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    arm = 1'b0;
    @(negedge clk);
  endtask

  task automatic model_byte(input logic [1:0] m, input logic [7:0] d, input int max_words);
    int rows = int'(m) + 1;
    int left = 8;
    int i = 7;
    int w = 0;
    while (left > 0 && w < max_words) begin
      int take;
      take = (rows < left) ? rows : left;
      for (int r = 0; r < take; r++) begin
        if (msub == hw_sub) mram[mptr][r] = d[i];
        i--;
      end
      left -= take;
      w++;
      if (mptr >= NW - 1) begin
        mptr = 0;
        msub = msub + 3'd1;
      end else mptr++;
    end
  endtask

  task automatic load_ptr(input int v);
    @(negedge clk); ptr_load = 1'b1; ptr_val = 6'(v);
    @(negedge clk); ptr_load = 1'b0;
    mptr = v;
  endtask

  task automatic select_dev(input logic [2:0] v);
    @(negedge clk); dev_sel = 1'b1; dev_val = v;
    @(negedge clk); dev_sel = 1'b0;
    msub = v;
  endtask

  task automatic send_byte(input logic [1:0] m, input logic [7:0] d,
                           input bit inject, input int abort_at);
    int words = (8 + int'(m)) / (int'(m) + 1);
    int cnt = 0;
    mode = m;
    @(negedge clk); byte_valid = 1'b1; byte_data = d;
    @(negedge clk); byte_valid = 1'b0;
    while (busy) begin
      cnt++;
      ptr_load = 1'b0; dev_sel = 1'b0; byte_valid = 1'b0; abort = 1'b0;
      if (inject && cnt == 2) begin
        ptr_load = 1'b1; ptr_val = 6'd20;
        dev_sel = 1'b1; dev_val = 3'd5;
        byte_valid = 1'b1; byte_data = 8'hFF;
      end
      if (abort_at >= 0 && cnt == abort_at + 1) abort = 1'b1;
      @(negedge clk);
      if (cnt > 20) break;
    end
    ptr_load = 1'b0; dev_sel = 1'b0; byte_valid = 1'b0; abort = 1'b0;
    if (abort_at >= 0) begin
      model_byte(m, d, abort_at);
      check("R10 busy cycles with abort", cnt, abort_at + 1);
    end else begin
      model_byte(m, d, 99);
      check("R9 busy cycles", cnt, words);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int a = 0; a < NW; a++) mram[a] = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", int'(busy), 0);

    // R1: stream from reset pointer 0 / counter 0, clearing all words
    hw_sub = 3'd0;
    for (int k = 0; k < 20; k++) send_byte(2'd3, 8'h00, 0, -1);
    check_all("R1");
    select_dev(3'd0);

    // R5: four rows per word
    load_ptr(10);
    send_byte(2'd3, 8'hA5, 0, -1);
    check_all("R5");

    // R2: static, upper rows preset to ones must stay
    load_ptr(0);
    for (int k = 0; k < 4; k++) send_byte(2'd3, 8'hFF, 0, -1);
    load_ptr(0);
    send_byte(2'd0, 8'h5A, 0, -1);
    send_byte(2'd3, 8'h81, 0, -1);   // R2 pointer advanced by 8 -> words 8,9
    check_all("R2");

    // R3: two rows per word
    load_ptr(20);
    send_byte(2'd3, 8'hFF, 0, -1);
    send_byte(2'd3, 8'hFF, 0, -1);
    load_ptr(20);
    send_byte(2'd1, 8'h96, 0, -1);
    send_byte(2'd3, 8'h3C, 0, -1);   // R3 pointer advanced by 4
    check_all("R3");

    // R4: three rows, row 2 of third word kept
    load_ptr(30);
    send_byte(2'd3, 8'hFF, 0, -1);
    send_byte(2'd3, 8'hFF, 0, -1);
    load_ptr(30);
    send_byte(2'd2, 8'h00, 0, -1);
    send_byte(2'd2, 8'hB7, 0, -1);   // R4 pointer advanced by 3
    check_all("R4");

    // R6: mismatch blocks storage, pointer still moves; R8 select
    hw_sub = 3'd3;
    select_dev(3'd0);
    load_ptr(5);
    send_byte(2'd3, 8'h00, 0, -1);
    select_dev(3'd3);
    send_byte(2'd3, 8'hC9, 0, -1);
    check_all("R6");

    // R7: hand-over inside a static byte
    select_dev(3'd2);
    load_ptr(38);
    send_byte(2'd0, 8'hE1, 0, -1);
    send_byte(2'd0, 8'h0F, 0, -1);
    check_all("R7");

    // R9: strobes while busy ignored
    load_ptr(14);
    send_byte(2'd0, 8'h00, 1, -1);
    send_byte(2'd3, 8'h6B, 0, -1);
    check_all("R9");

    // R10: abort after two words
    load_ptr(12);
    send_byte(2'd0, 8'hFF, 0, 2);
    check_all("R10");

    // R11 with R8: random placements in all modes
    for (int k = 0; k < 8; k++) begin
      select_dev(3'(($urandom % 2) + 2));
      load_ptr(int'($urandom % NW));
      send_byte(2'($urandom % 4), 8'($urandom), 0, -1);
      check_all("R11");
    end

    check("R11 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule